// File: doc/BRIEF.md
# Nonvolatile SRAM Store Controller

This block sequences the copy of an SRAM into its nonvolatile shadow array. A store can be requested from three sources: a shared active-low handshake line (open-drain, wire-ORed with other controllers), a rising edge on a power-fail flag, or a software request pulse. A grace period of `DELAY_CYC` cycles follows every accepted request. During it reads keep flowing, new writes are refused, and a write already under way may still complete. At the end of the period the controller starts the copy only if the SRAM holds data that is newer than the last store or recall. Otherwise it reports a skipped store.

While the copy runs, the controller pulls the shared line low to signal busy. It releases the line when the array reports done. All SRAM access then stays off until the line is seen high again. A power-fail request first tries to pull the line low for `ONSET_CYC` cycles. If the line never reads low in that window, something outside is holding it high, so the controller lets go and reports an abort. Two inputs can block requests. The low-supply flag blocks line and software requests and all writes. The auto-inhibit input blocks power-fail requests.

The nonvolatile array is modelled by the `nv_start` / `nv_done` pair. Supply sensing arrives as digital flags.

Top module: `nvsram_store_ctrl`

## Requirements
- R1: With `low_supply` low, a high-to-low transition of `line_n_in`, seen after a two-flop synchronizer, moves the controller from idle into the grace period. The grace period lasts exactly `DELAY_CYC` cycles.
- R2: When the grace period ends with the dirty flag set, `nv_start` pulses for one cycle together with the first cycle of the store state. When it ends with the flag clear, `skip_pulse` pulses for one cycle instead and `nv_start` stays low.
- R3: The dirty flag is set by `wr_commit` in any state. It is cleared by `nv_done` during a store or by `recall_done`.
- R4: During the grace period `rd_allow` is 1 and `wr_allow` is 0. A `wr_commit` arriving inside the grace period still marks the SRAM dirty.
- R5: During the store state `busy_drive` is 1 and both `rd_allow` and `wr_allow` are 0. This holds until `nv_done` arrives.
- R6: After a store or a skip, the controller waits with both access enables at 0 until the synchronized line reads high. It then returns to idle with `wr_allow` at 1.
- R7: With `auto_inhibit` low, a rising edge of `pwr_fail` sets `busy_drive` for up to `ONSET_CYC` cycles. If the line reads low in that window, the grace period follows and the line stays driven. If it does not, the controller shows the aborted status for one cycle with `busy_drive` at 0, and no store starts.
- R8: With `auto_inhibit` high, `pwr_fail` edges have no effect, while software and line requests still work.
- R9: With `low_supply` high, `wr_allow` is 0 from the next cycle on, and line falls and `sw_store_req` pulses are ignored.
- R10: A one-cycle `sw_store_req` in idle starts the grace period without driving the line. Priority is power-fail, then software, then the line.
- R11: `status` encodes idle=0, grace=1, store=2, wait-for-release=3, aborted=4, power-fail onset=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_n_in | input | 1 | Sampled level of the shared active-low busy/request line (asynchronous) |
| busy_drive | output | 1 | 1 = pull the shared line low (open-drain enable) |
| pwr_fail | input | 1 | Power-fail comparator flag; rising edge requests a store |
| low_supply | input | 1 | Capacitor below switch threshold; inhibits writes and line/software requests |
| auto_inhibit | input | 1 | 1 = ignore power-fail requests |
| sw_store_req | input | 1 | One-cycle software store request |
| wr_commit | input | 1 | An SRAM write completed this cycle |
| recall_done | input | 1 | A recall from the shadow array completed this cycle |
| nv_done | input | 1 | Nonvolatile copy finished |
| nv_start | output | 1 | One-cycle pulse starting the nonvolatile copy |
| wr_allow | output | 1 | SRAM writes permitted |
| rd_allow | output | 1 | SRAM reads permitted |
| skip_pulse | output | 1 | One-cycle pulse: request served without a store (data clean) |
| status | output | 3 | Controller state code (see R11) |

## Verification
On every cycle, the bound checker enforces the access enables for each state: reads on with writes off in the grace period, everything off while storing or waiting for release, and no writes one cycle after `low_supply`. It also checks that the line is driven throughout the onset and store states, that it is released when aborted, and that `nv_start` can only come straight out of the grace period and never together with `skip_pulse`. Only the bench scenarios can show the rest. That includes the exact length of the grace period, whether a store or a skip follows from the write and recall history, the abort when the line is stuck high, and the release wait ending on an external line release. It also covers the cases where `auto_inhibit` or `low_supply` should leave the controller idle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DELAY = 3'd1,
    ST_STORE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_ABORT = 3'd4,
    ST_ONSET = 3'd5
  } nvs_state_e;
endpackage

// File: rtl/nvs_line_sync.sv
module nvs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_async,
  output logic level,
  output logic fall
);
  // sh[0..STAGES-1] synchronize, sh[STAGES] holds the previous synchronized level
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], din_async};
  end

  assign level = sh[STAGES-1];
  assign fall  = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/nvs_countdown.sv
module nvs_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nvs_dirty.sv
module nvs_dirty (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic dirty
);
  always_ff @(posedge clk) begin
    if (rst)      dirty <= 1'b0;
    else if (set) dirty <= 1'b1;   // a fresh write outranks a clear in the same cycle
    else if (clr) dirty <= 1'b0;
  end
endmodule

// File: rtl/nvsram_store_ctrl.sv
module nvsram_store_ctrl
  import nvs_pkg::*;
#(
  parameter int DELAY_CYC   = 64,
  parameter int ONSET_CYC   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_n_in,
  output logic       busy_drive,
  input  logic       pwr_fail,
  input  logic       low_supply,
  input  logic       auto_inhibit,
  input  logic       sw_store_req,
  input  logic       wr_commit,
  input  logic       recall_done,
  input  logic       nv_done,
  output logic       nv_start,
  output logic       wr_allow,
  output logic       rd_allow,
  output logic       skip_pulse,
  output logic [2:0] status
);
  localparam int MAXC = (DELAY_CYC > ONSET_CYC) ? DELAY_CYC : ONSET_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] DLY_LOAD = TW'(DELAY_CYC - 1);
  localparam logic [TW-1:0] ONS_LOAD = TW'(ONSET_CYC - 1);

  nvs_state_e state, state_n;
  logic own, own_n;          // controller itself is pulling the line (power-fail path)
  logic line_hi, line_fall;
  logic pwr_q, pwr_rise;
  logic t_zero, t_load;
  logic [TW-1:0] t_val;
  logic dirty, dirty_clr;

  nvs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din_async(line_n_in),
    .level(line_hi), .fall(line_fall)
  );

  nvs_countdown #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  assign dirty_clr = (state == ST_STORE && nv_done) || recall_done;

  nvs_dirty u_dirty (
    .clk(clk), .rst(rst), .set(wr_commit), .clr(dirty_clr), .dirty(dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) pwr_q <= 1'b0;
    else     pwr_q <= pwr_fail;
  end
  assign pwr_rise = pwr_fail & ~pwr_q;

  always_comb begin
    state_n = state;
    own_n   = own;
    unique case (state)
      ST_IDLE: begin
        if (pwr_rise && !auto_inhibit) begin
          state_n = ST_ONSET;
          own_n   = 1'b1;
        end else if (!low_supply && sw_store_req) begin
          state_n = ST_DELAY;
        end else if (!low_supply && line_fall) begin
          state_n = ST_DELAY;
        end
      end
      ST_ONSET: begin
        if (!line_hi) begin
          state_n = ST_DELAY;
        end else if (t_zero) begin
          state_n = ST_ABORT;
          own_n   = 1'b0;
        end
      end
      ST_DELAY: begin
        if (t_zero) begin
          if (dirty) begin
            state_n = ST_STORE;
          end else begin
            state_n = ST_WAIT;
            own_n   = 1'b0;
          end
        end
      end
      ST_STORE: begin
        if (nv_done) begin
          state_n = ST_WAIT;
          own_n   = 1'b0;
        end
      end
      ST_WAIT: begin
        if (line_hi) state_n = ST_IDLE;
      end
      ST_ABORT: state_n = ST_IDLE;
      default: begin
        state_n = ST_IDLE;
        own_n   = 1'b0;
      end
    endcase
  end

  assign t_load = (state_n != state) && (state_n == ST_DELAY || state_n == ST_ONSET);
  assign t_val  = (state_n == ST_DELAY) ? DLY_LOAD : ONS_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      own        <= 1'b0;
      busy_drive <= 1'b0;
      nv_start   <= 1'b0;
      skip_pulse <= 1'b0;
      wr_allow   <= 1'b0;
      rd_allow   <= 1'b1;
    end else begin
      state      <= state_n;
      own        <= own_n;
      busy_drive <= own_n || (state_n == ST_STORE);
      nv_start   <= (state == ST_DELAY) && (state_n == ST_STORE);
      skip_pulse <= (state == ST_DELAY) && (state_n == ST_WAIT);
      wr_allow   <= (state_n == ST_IDLE) && !low_supply && line_hi;
      rd_allow   <= (state_n == ST_IDLE) || (state_n == ST_DELAY) ||
                    (state_n == ST_ONSET) || (state_n == ST_ABORT);
    end
  end

  assign status = state;
endmodule

// File: rtl/nvs_store_checker.sv
module nvs_store_checker
  import nvs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] status,
  input logic       busy_drive,
  input logic       nv_start,
  input logic       skip_pulse,
  input logic       wr_allow,
  input logic       rd_allow,
  input logic       low_supply
);
  assert_grace_access_R4: assert property (@(posedge clk) disable iff (rst)
    status == ST_DELAY |-> rd_allow && !wr_allow);

  assert_store_holds_line_R5: assert property (@(posedge clk) disable iff (rst)
    status == ST_STORE |-> busy_drive && !rd_allow && !wr_allow);

  assert_release_wait_locked_R6: assert property (@(posedge clk) disable iff (rst)
    status == ST_WAIT |-> !rd_allow && !wr_allow);

  assert_start_from_grace_R2: assert property (@(posedge clk) disable iff (rst)
    nv_start |-> status == ST_STORE && $past(status) == ST_DELAY);

  assert_skip_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    skip_pulse |-> !nv_start && status == ST_WAIT);

  assert_onset_drives_R7: assert property (@(posedge clk) disable iff (rst)
    status == ST_ONSET |-> busy_drive);

  assert_abort_releases_R7: assert property (@(posedge clk) disable iff (rst)
    status == ST_ABORT |-> !busy_drive && !nv_start);

  assert_low_supply_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(low_supply) |-> !wr_allow);

  assert_status_legal_R11: assert property (@(posedge clk) disable iff (rst)
    status <= 3'd5);
endmodule

bind nvsram_store_ctrl nvs_store_checker u_chk (
  .clk(clk), .rst(rst), .status(status), .busy_drive(busy_drive),
  .nv_start(nv_start), .skip_pulse(skip_pulse), .wr_allow(wr_allow),
  .rd_allow(rd_allow), .low_supply(low_supply)
);

// File: tb/tb_nvsram_store_ctrl.sv
module tb_nvsram_store_ctrl;
  localparam int DLY = 6;
  localparam int ONS = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pull = 1'b0, stuck_high = 1'b0;
  logic pwr_fail = 1'b0, low_supply = 1'b0, auto_inhibit = 1'b0;
  logic sw_store_req = 1'b0, wr_commit = 1'b0, recall_done = 1'b0, nv_done = 1'b0;
  logic busy_drive, nv_start, wr_allow, rd_allow, skip_pulse;
  logic [2:0] status;
  logic line_n;

  int errors = 0;
  int checks = 0;
  bit mdl_dirty = 1'b0;

  always #5 clk = ~clk;

  // wired-OR open-drain line with pull-up; stuck_high models a strong external driver
  assign line_n = stuck_high | ~(busy_drive | ext_pull);

  nvsram_store_ctrl #(.DELAY_CYC(DLY), .ONSET_CYC(ONS)) dut (
    .clk(clk), .rst(rst), .line_n_in(line_n), .busy_drive(busy_drive),
    .pwr_fail(pwr_fail), .low_supply(low_supply), .auto_inhibit(auto_inhibit),
    .sw_store_req(sw_store_req), .wr_commit(wr_commit), .recall_done(recall_done),
    .nv_done(nv_done), .nv_start(nv_start), .wr_allow(wr_allow),
    .rd_allow(rd_allow), .skip_pulse(skip_pulse), .status(status)
  );

  function automatic int exp_store_count(input bit d);
    return d ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic write_one();
    @(negedge clk); wr_commit = 1'b1;
    @(negedge clk); wr_commit = 1'b0;
    mdl_dirty = 1'b1;
  endtask

  task automatic recall_one();
    @(negedge clk); recall_done = 1'b1;
    @(negedge clk); recall_done = 1'b0;
    mdl_dirty = 1'b0;
  endtask

  // kind: 0 line, 1 software, 2 power-fail
  task automatic run_request(input int kind, input bit commit_in_delay);
    int delay_n = 0, starts = 0, skips = 0, bad_grace = 0, bad_store = 0;
    int bad_wait = 0, wait_n = 0, done_cnt = 0;
    bit wait_seen = 0, back_idle = 0, exp_store;
    @(negedge clk);
    if (kind == 0) ext_pull = 1'b1;
    else if (kind == 1) sw_store_req = 1'b1;
    else pwr_fail = 1'b1;
    for (int i = 0; i < 300 && !back_idle; i++) begin
      @(negedge clk);
      sw_store_req = 1'b0;
      wr_commit = 1'b0;
      if (done_cnt > 0) begin done_cnt--; nv_done = (done_cnt == 0); end
      else nv_done = 1'b0;
      if (nv_start) begin starts++; done_cnt = 3; end
      if (skip_pulse) skips++;
      if (status == 3'd1) begin
        delay_n++;
        if (!rd_allow || wr_allow) bad_grace++;
        if (commit_in_delay && delay_n == 1) begin wr_commit = 1'b1; mdl_dirty = 1'b1; end
      end
      if (status == 3'd2 && (!busy_drive || rd_allow || wr_allow)) bad_store++;
      if (status == 3'd3) begin
        wait_seen = 1;
        wait_n++;
        if (rd_allow || wr_allow) bad_wait++;
        if (wait_n == 4) ext_pull = 1'b0;
      end
      if (status == 3'd0 && wait_seen) back_idle = 1;
    end
    nv_done = 1'b0;
    pwr_fail = 1'b0;
    ext_pull = 1'b0;
    exp_store = mdl_dirty;
    check(delay_n == DLY, "R1 grace length", delay_n, DLY);
    check(starts == exp_store_count(exp_store), "R2/R3 store starts", starts, exp_store_count(exp_store));
    check(skips == 1 - exp_store_count(exp_store), "R2 skip pulses", skips, 1 - exp_store_count(exp_store));
    check(bad_grace == 0, "R4 grace access", bad_grace, 0);
    check(bad_store == 0, "R5 store busy", bad_store, 0);
    check(bad_wait == 0 && back_idle, "R6 release wait", bad_wait, 0);
    @(negedge clk);
    check(wr_allow == 1'b1 && status == 3'd0, "R6 idle access restored", int'(wr_allow), 1);
    if (exp_store) mdl_dirty = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // reset state (R11 idle code)
    check(status == 3'd0, "R11 reset status", int'(status), 0);
    check(busy_drive == 1'b0 && nv_start == 1'b0 && skip_pulse == 1'b0, "R5 reset outputs", int'(busy_drive), 0);
    check(rd_allow == 1'b1, "R4 reset reads", int'(rd_allow), 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(wr_allow == 1'b1, "R6 writes after reset", int'(wr_allow), 1);

    // clean line request: skip; R1 R2
    run_request(0, 0);
    // dirty line request: store; R3 R5
    write_one();
    run_request(0, 0);
    // write completing inside grace still counts: R4 R3
    run_request(1, 1);
    // software request on clean data: R10
    run_request(1, 0);
    // recall clears dirty: R3
    write_one(); recall_one();
    run_request(0, 0);
    // power-fail store: R7
    write_one();
    run_request(2, 0);

    // power-fail with line stuck high: abort (R7)
    begin
      int onset_n = 0, aborts = 0, starts = 0, bad_drive = 0;
      stuck_high = 1'b1;
      write_one();
      @(negedge clk); pwr_fail = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (status == 3'd5) begin onset_n++; if (!busy_drive) bad_drive++; end
        if (status == 3'd4) begin aborts++; if (busy_drive) bad_drive++; end
        if (nv_start) starts++;
      end
      pwr_fail = 1'b0; stuck_high = 1'b0;
      check(onset_n == ONS, "R7 onset length", onset_n, ONS);
      check(aborts == 1, "R7 abort status", aborts, 1);
      check(starts == 0 && bad_drive == 0, "R7 abort no store", starts + bad_drive, 0);
      check(status == 3'd0, "R7 back to idle", int'(status), 0);
    end

    // auto-inhibit: power-fail ignored, software still works (R8)
    begin
      int moved = 0;
      auto_inhibit = 1'b1;
      @(negedge clk); pwr_fail = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (status != 3'd0 || busy_drive) moved++;
      end
      pwr_fail = 1'b0;
      check(moved == 0, "R8 power-fail ignored", moved, 0);
      run_request(1, 0);
      auto_inhibit = 1'b0;
    end

    // low supply: writes off, requests ignored (R9)
    begin
      int moved = 0;
      @(negedge clk); low_supply = 1'b1;
      @(negedge clk); @(negedge clk);
      check(wr_allow == 1'b0, "R9 writes inhibited", int'(wr_allow), 0);
      ext_pull = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        sw_store_req = (i == 5);
        if (status != 3'd0) moved++;
      end
      sw_store_req = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (status != 3'd0) moved++;
      end
      check(moved == 0, "R9 requests ignored", moved, 0);
      ext_pull = 1'b0; low_supply = 1'b0;
      repeat (4) @(negedge clk);
      check(wr_allow == 1'b1, "R9 writes resume", int'(wr_allow), 1);
    end

    // constrained random mix of write/recall history and request sources
    for (int it = 0; it < 24; it++) begin
      int nops = $urandom_range(0, 3);
      for (int k = 0; k < nops; k++) begin
        if ($urandom_range(0, 3) == 0) recall_one();
        else write_one();
      end
      run_request($urandom_range(0, 2), $urandom_range(0, 4) == 0);
    end

    summary();
    $finish;
  end
endmodule